// File: doc/BRIEF.md
# Adaptive Equalizer Setting Search Controller

This controller hunts for a working receiver setting by stepping through equalizer gain codes and sampling-delay codes. Each candidate setting is held for a programmable relock time and then judged. In single-step mode the judgement is the lock indication seen in the last cycle of the hold. In two-step mode the controller also counts link errors during the second half of the hold. It abandons the candidate as soon as the count goes above a threshold, and otherwise judges on lock at the end of the hold.

The delay search can be nested inside or outside the equalizer search. It can start at the largest clock delay or at the midpoint, and it can be turned off so that only equalizer codes are swept. When every combination fails, the codes wrap back to their starting values and the sweep runs again. The controller raises `done` when a setting passes. It stays on that setting until lock is lost or a restart is requested. The equalizer, the clock recovery and the error detectors sit outside the block.

States: `ST_LOAD` (capture the configuration and set the initial codes), `ST_EVAL` (hold the current setting and judge it), `ST_STEP` (move to the next setting), `ST_DONE` (setting accepted). Transitions: LOAD→EVAL always. EVAL→STEP on early error exit or on failed lock at the end of the hold. EVAL→DONE on lock at the end of the hold. STEP→EVAL always. DONE→LOAD on lock loss. Any state→LOAD on `restart`.

Top module: `aeq_search_fsm`

## Requirements
- R1: During and right after reset the outputs are `eq_code`=0, `dly_code`=0 and `done`=0.
- R2: Each setting is held for `relock_time` cycles (values below 2 are taken as 2), followed by one stepping cycle. With two-step mode off and lock low, successive code changes are therefore `relock_time`+1 cycles apart.
- R3: With two-step mode off, the setting is accepted when `lock` is high in the last hold cycle, whatever errors occur. `done` then rises and the codes stay unchanged.
- R4: In two-step mode, errors are counted only in hold cycles whose index (0-based) is at least `relock_time`/2, rounded down. Errors in the first half have no effect.
- R5: In two-step mode, the hold ends in the cycle where the running error count first exceeds `err_thresh`, and the controller steps on. A count equal to the threshold does not reject the setting.
- R6: `err_mask` bit 2 enables clock-pattern errors (`err_clk`), bit 1 enables sequence errors (`err_seq`) and bit 0 enables parity errors (`err_par`). Each enabled class adds one per cycle in which its pulse is high. Disabled classes are never counted.
- R7: With `eq_outer`=0 and the delay search on, the equalizer code advances by one at every step. The delay position advances only when the equalizer code wraps from 15 to 0.
- R8: With `eq_outer`=1 and the delay search on, the delay position advances at every step. The equalizer code advances only when the delay position wraps.
- R9: `dly_code` equals the delay position plus an offset, modulo 16. The offset is 0 (largest clock delay first) when `dly_mid_start`=0 and 8 (midpoint first) when it is 1.
- R10: With `dly_search_en`=0, `dly_code` stays at its starting value. Only the equalizer code steps, wrapping from 15 to 0.
- R11: After all 256 combinations fail, the codes are back at their initial values and the sweep repeats.
- R12: `done` stays high while `lock` stays high. Loss of lock, or a `restart` pulse in any state, clears `done` and restores the initial codes two cycles later.
- R13: All configuration inputs are captured in `ST_LOAD`. Changes after that do not affect the search in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| restart | input | 1 | Restart the search from the initial codes |
| relock_time | input | 16 | Hold length per setting, in cycles |
| err_mask | input | 3 | Enabled error classes: [2] clock pattern, [1] sequence, [0] parity |
| err_thresh | input | 8 | Error count that must be exceeded to reject a setting |
| two_step | input | 1 | 1: error window in the second half of the hold |
| eq_outer | input | 1 | 1: equalizer is the outer loop |
| dly_mid_start | input | 1 | 1: delay search starts at the midpoint |
| dly_search_en | input | 1 | 1: include the delay search |
| lock | input | 1 | Receiver lock indication |
| err_clk | input | 1 | Clock-pattern error pulse |
| err_seq | input | 1 | Sequence error pulse |
| err_par | input | 1 | Parity error pulse |
| eq_code | output | 4 | Current equalizer code |
| dly_code | output | 4 | Current sampling-delay code |
| done | output | 1 | A valid setting has been found |

## Verification
The main sweep is tried with a table of target settings. The lock input follows the outputs and rises only when the codes hit the target. The table covers both nestings, both delay start points, and the delay search on and off. The number of code changes before `done` tells apart the nesting order, the start offset and the modulo wrap of the delay sequence. Error patterns are a single class, two classes, masked classes, and thresholds just below and equal to the count reached in the late half. The measured spacing of code changes tells early exit apart from counting over the whole hold. Directed runs cover lock loss, restart during the search, the full 256-setting wrap and configuration changes in the middle of a search.

// File: rtl/aeq_pkg.sv
package aeq_pkg;
    typedef enum logic [1:0] {
        ST_LOAD,
        ST_EVAL,
        ST_STEP,
        ST_DONE
    } aeq_state_e;

    typedef struct packed {
        logic       two_step;
        logic       eq_outer;
        logic       dly_en;
        logic [2:0] mask;
    } aeq_cfg_t;
endpackage

// File: rtl/aeq_window_timer.sv
module aeq_window_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [TW-1:0] span,
    output logic          last,
    output logic          late_half
);
    logic [TW-1:0] t_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   t_q <= '0;
        else if (run) t_q <= t_q + 1'b1;
        else          t_q <= '0;
    end

    assign last      = run && (t_q == span - 1'b1);
    assign late_half = run && (t_q >= (span >> 1));

    // R2
    window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (t_q < span));
endmodule

// File: rtl/aeq_err_acc.sv
module aeq_err_acc #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          count_en,
    input  logic [2:0]    mask,
    input  logic          err_clk,
    input  logic          err_seq,
    input  logic          err_par,
    input  logic [CW-1:0] thresh,
    output logic          over
);
    logic [CW-1:0] cnt_q;
    logic [2:0]    hits;
    logic [1:0]    inc;
    logic [CW:0]   wide;
    logic [CW-1:0] sum;

    always_comb begin
        hits = mask & {err_clk, err_seq, err_par};
        inc  = {1'b0, hits[0]} + {1'b0, hits[1]} + {1'b0, hits[2]};
        wide = {1'b0, cnt_q} + {{(CW-1){1'b0}}, inc};
        sum  = wide[CW] ? '1 : wide[CW-1:0];
        over = count_en && (sum > thresh);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (clr)      cnt_q <= '0;
        else if (count_en) cnt_q <= sum;
    end

    // R4
    count_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && !clr) |=> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/aeq_code_stepper.sv
module aeq_code_stepper #(
    parameter int EQ_W  = 4,
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic             mid_start,
    input  logic             eq_outer,
    input  logic             dly_en,
    output logic [EQ_W-1:0]  eq_code,
    output logic [DLY_W-1:0] dly_code
);
    localparam logic [EQ_W-1:0]  EQ_MAX  = '1;
    localparam logic [DLY_W-1:0] POS_MAX = '1;
    localparam logic [DLY_W-1:0] MID_OFS = DLY_W'(1) << (DLY_W - 1);

    logic [EQ_W-1:0]  eq_q, eq_n;
    logic [DLY_W-1:0] pos_q, pos_n, ofs_q;

    always_comb begin
        eq_n  = eq_q;
        pos_n = pos_q;
        if (!dly_en) begin
            eq_n = eq_q + 1'b1;
        end else if (!eq_outer) begin
            eq_n = eq_q + 1'b1;
            if (eq_q == EQ_MAX) pos_n = pos_q + 1'b1;
        end else begin
            pos_n = pos_q + 1'b1;
            if (pos_q == POS_MAX) eq_n = eq_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eq_q  <= '0;
            pos_q <= '0;
            ofs_q <= '0;
        end else if (load) begin
            eq_q  <= '0;
            pos_q <= '0;
            ofs_q <= mid_start ? MID_OFS : '0;
        end else if (step) begin
            eq_q  <= eq_n;
            pos_q <= pos_n;
        end
    end

    assign eq_code  = eq_q;
    assign dly_code = pos_q + ofs_q;

    // R10
    dly_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !dly_en) |=> $stable(dly_code));
    // R7
    eq_inner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && dly_en && !eq_outer && eq_q != EQ_MAX) |=> $stable(dly_code));
    // R8
    eq_outer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && dly_en && eq_outer && pos_q != POS_MAX) |=> $stable(eq_code));
endmodule

// File: rtl/aeq_search_fsm.sv
module aeq_search_fsm
    import aeq_pkg::*;
#(
    parameter int TW    = 16,
    parameter int CW    = 8,
    parameter int EQ_W  = 4,
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [TW-1:0]    relock_time,
    input  logic [2:0]       err_mask,
    input  logic [CW-1:0]    err_thresh,
    input  logic             two_step,
    input  logic             eq_outer,
    input  logic             dly_mid_start,
    input  logic             dly_search_en,
    input  logic             lock,
    input  logic             err_clk,
    input  logic             err_seq,
    input  logic             err_par,
    output logic [EQ_W-1:0]  eq_code,
    output logic [DLY_W-1:0] dly_code,
    output logic             done
);
    localparam logic [TW-1:0] MIN_SPAN = TW'(2);

    aeq_state_e    state_q, state_n;
    aeq_cfg_t      cfg_q;
    logic [TW-1:0] span_q;
    logic [CW-1:0] thr_q;
    logic          last, late_half, over;
    logic          in_eval;

    assign in_eval = (state_q == ST_EVAL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '{two_step: 1'b0, eq_outer: 1'b0, dly_en: 1'b1, mask: 3'b111};
            span_q <= MIN_SPAN;
            thr_q  <= '0;
        end else if (state_q == ST_LOAD) begin
            cfg_q  <= '{two_step: two_step, eq_outer: eq_outer,
                        dly_en: dly_search_en, mask: err_mask};
            span_q <= (relock_time < MIN_SPAN) ? MIN_SPAN : relock_time;
            thr_q  <= err_thresh;
        end
    end

    aeq_window_timer #(.TW(TW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (in_eval),
        .span      (span_q),
        .last      (last),
        .late_half (late_half)
    );

    aeq_err_acc #(.CW(CW)) u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!in_eval),
        .count_en (in_eval && cfg_q.two_step && late_half),
        .mask     (cfg_q.mask),
        .err_clk  (err_clk),
        .err_seq  (err_seq),
        .err_par  (err_par),
        .thresh   (thr_q),
        .over     (over)
    );

    aeq_code_stepper #(.EQ_W(EQ_W), .DLY_W(DLY_W)) u_codes (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (state_q == ST_LOAD),
        .step      (state_q == ST_STEP),
        .mid_start (dly_mid_start),
        .eq_outer  (cfg_q.eq_outer),
        .dly_en    (cfg_q.dly_en),
        .eq_code   (eq_code),
        .dly_code  (dly_code)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_LOAD: state_n = ST_EVAL;
            ST_EVAL: begin
                if (over)      state_n = ST_STEP;
                else if (last) state_n = lock ? ST_DONE : ST_STEP;
            end
            ST_STEP: state_n = ST_EVAL;
            ST_DONE: if (!lock) state_n = ST_LOAD;
            default: state_n = ST_LOAD;
        endcase
        if (restart) state_n = ST_LOAD;
    end

    always_comb begin
        done = 1'b0;
        unique case (state_q)
            ST_DONE: done = 1'b1;
            default: done = 1'b0;
        endcase
    end

    // R5
    early_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_eval && over && !restart) |=> (state_q == ST_STEP));
    // R3
    done_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(lock));
    // R12
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !lock) |=> (state_q == ST_LOAD));
    // R1
    init_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state_q == ST_LOAD) |-> (eq_code == '0));
    // R2
    hold_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_eval && $past(in_eval)) |-> ($stable(eq_code) && $stable(dly_code)));
endmodule

// File: tb/tb_aeq_search_fsm.sv
module tb_aeq_search_fsm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart = 1'b0;
    logic [15:0] relock_time = 16'd8;
    logic [2:0]  err_mask = 3'b111;
    logic [7:0]  err_thresh = 8'd0;
    logic        two_step = 1'b0, eq_outer = 1'b0, dly_mid_start = 1'b0, dly_search_en = 1'b1;
    logic        lock = 1'b0, err_clk = 1'b0, err_seq = 1'b0, err_par = 1'b0;
    logic [3:0]  eq_code, dly_code;
    logic        done;

    int checks = 0, failures = 0, chg = 0, dly_moves = 0, lock_mode = 2;
    logic [3:0] tgt_eq = 0, tgt_dly = 0, prev_eq = 0, prev_dly = 0;
    bit finished = 0;

    // {expected changes[19:12], two_step, eq_outer, mid, dly_en, eq[7:4], dly[3:0]}
    localparam logic [19:0] VECS [8] = '{
        {8'd5,  4'b0001, 4'd5, 4'd0},
        {8'd50, 4'b0001, 4'd2, 4'd3},
        {8'd35, 4'b0101, 4'd2, 4'd3},
        {8'd17, 4'b0011, 4'd1, 4'd9},
        {8'd10, 4'b0111, 4'd0, 4'd2},
        {8'd7,  4'b1000, 4'd7, 4'd0},
        {8'd31, 4'b1101, 4'd1, 4'd15},
        {8'd4,  4'b0110, 4'd4, 4'd8}
    };

    aeq_search_fsm dut (
        .clk(clk), .rst_n(rst_n), .restart(restart), .relock_time(relock_time),
        .err_mask(err_mask), .err_thresh(err_thresh), .two_step(two_step),
        .eq_outer(eq_outer), .dly_mid_start(dly_mid_start), .dly_search_en(dly_search_en),
        .lock(lock), .err_clk(err_clk), .err_seq(err_seq), .err_par(err_par),
        .eq_code(eq_code), .dly_code(dly_code), .done(done)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        case (lock_mode)
            0:       lock <= (eq_code == tgt_eq) && (dly_code == tgt_dly);
            1:       lock <= 1'b1;
            default: lock <= 1'b0;
        endcase
        if (eq_code != prev_eq || dly_code != prev_dly) chg <= chg + 1;
        if (dly_code != prev_dly) dly_moves <= dly_moves + 1;
        prev_eq  <= eq_code;
        prev_dly <= dly_code;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic sync();
        @(posedge clk); #1;
    endtask

    task automatic do_restart();
        sync(); restart = 1'b1;
        sync(); restart = 1'b0;
        repeat (2) sync();
    endtask

    task automatic wait_done(input int cap);
        for (int i = 0; i < cap && !done; i++) sync();
    endtask

    task automatic wait_chg(input int base, input int n, input int cap);
        for (int i = 0; i < cap && (chg - base) < n; i++) sync();
    endtask

    task automatic period(output int p);
        int b;
        realtime t0;
        b = chg;
        wait_chg(b, 1, 400);
        t0 = $realtime;
        wait_chg(b, 2, 400);
        p = int'(($realtime - t0) / 20.0);
    endtask

    initial begin
        int p, base;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(eq_code == 0 && dly_code == 0 && done == 0, "R1 reset", {eq_code, dly_code}, 0);
        sync(); rst_n = 1'b1;
        sync();
        check(eq_code == 0 && done == 0, "R1 after reset", eq_code, 0);

        // Table: R7 R8 R9 R10 nesting, start offset, delay search enable
        relock_time = 16'd4;
        lock_mode = 0;
        foreach (VECS[k]) begin
            sync();
            two_step = VECS[k][11]; eq_outer = VECS[k][10];
            dly_mid_start = VECS[k][9]; dly_search_en = VECS[k][8];
            tgt_eq = VECS[k][7:4]; tgt_dly = VECS[k][3:0];
            do_restart();
            base = chg;
            wait_done(3000);
            check(done && eq_code == tgt_eq && dly_code == tgt_dly, "R7 R8 R9 table codes",
                  {eq_code, dly_code}, {tgt_eq, tgt_dly});
            check(chg - base == int'(VECS[k][19:12]), "R10 table step count",
                  chg - base, int'(VECS[k][19:12]));
        end

        // R2: one-step, lock low -> period relock+1
        relock_time = 16'd8; two_step = 0; dly_search_en = 0; dly_mid_start = 0; eq_outer = 0;
        lock_mode = 2;
        do_restart();
        period(p);
        check(p == 9, "R2 hold period", p, 9);

        // R3: one-step ignores errors; lock high accepts first setting
        lock_mode = 1; err_clk = 1; err_seq = 1; err_par = 1;
        do_restart();
        wait_done(100);
        check(done && eq_code == 0, "R3 accept despite errors", eq_code, 0);

        // R5: two-step, threshold 0, parity errors every cycle -> exit at index 4
        two_step = 1; err_mask = 3'b001; err_thresh = 0;
        err_clk = 0; err_seq = 0; err_par = 1;
        do_restart();
        period(p);
        check(p == 6, "R5 early exit period", p, 6);
        check(done == 0, "R5 never accepted", done, 0);

        // R4: threshold 3, one class: only late-half errors count -> exit at last cycle
        err_thresh = 3;
        do_restart();
        period(p);
        check(p == 9, "R4 late-half counting", p, 9);

        // R6: two enabled classes add two per cycle -> exit at index 5
        err_mask = 3'b011; err_seq = 1;
        do_restart();
        period(p);
        check(p == 7, "R6 two classes counted", p, 7);

        // R6: masked-out classes never counted
        err_mask = 3'b100;
        do_restart();
        wait_done(100);
        check(done && eq_code == 0, "R6 masked classes ignored", eq_code, 0);

        // R5: count equal to threshold does not reject
        err_mask = 3'b001; err_seq = 0; err_thresh = 4;
        do_restart();
        wait_done(100);
        check(done && eq_code == 0, "R5 equal threshold accepted", eq_code, 0);

        // R12: done holds with lock, drops on lock loss, codes restored
        err_par = 0; two_step = 0; lock_mode = 0; tgt_eq = 3; tgt_dly = 0;
        do_restart();
        wait_done(200);
        repeat (20) sync();
        check(done && eq_code == 3, "R12 done held", eq_code, 3);
        lock_mode = 2;
        repeat (3) @(negedge clk);
        check(!done && eq_code == 0, "R12 lock loss reload", eq_code, 0);
        for (int i = 0; i < 400 && eq_code != 5; i++) sync();
        do_restart();
        check(!done && eq_code == 0, "R12 restart reload", eq_code, 0);

        // R10: delay search off -> delay fixed, eq wraps after 16 steps
        relock_time = 16'd2;
        do_restart();
        base = chg; p = dly_moves;
        wait_chg(base, 16, 2000);
        sync();
        check(eq_code == 0 && dly_code == 0 && dly_moves == p, "R10 eq-only wrap",
              dly_moves - p, 0);

        // R11: full wrap returns to initial codes (midpoint start)
        dly_search_en = 1; dly_mid_start = 1;
        do_restart();
        check(dly_code == 8, "R9 midpoint start", dly_code, 8);
        base = chg;
        wait_chg(base, 256, 3000);
        sync();
        check(eq_code == 0 && dly_code == 8, "R11 full wrap", {eq_code, dly_code}, 8);

        // R13: configuration changes after load have no effect
        dly_search_en = 0;
        do_restart();
        dly_mid_start = 0; dly_search_en = 1; eq_outer = 1;
        base = chg;
        wait_chg(base, 2, 200);
        sync();
        check(eq_code == 2 && dly_code == 8, "R13 config captured", {eq_code, dly_code}, 40);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule